// File: doc/BRIEF.md
# Glitch-Free Oscillator Output Gate

This block sits between a free-running oscillator clock and an output pin. It lets the clock through only when three conditions all hold: the start-up lockout after reset or after leaving power-down has finished, no power-down is in force, and at least one of two enables is set. One enable is a hardware pin and the other is a bit driven by a software register. The gate opens and closes only while the clock is low. Every output high phase is therefore complete, and the delay from enable to the first output edge is always the same.

A power-down request on its pin has to pass a persistence filter before it acts. The pin is first synchronised. It must then stay high for a minimum number of clock cycles, followed by a programmable number of reference-tick pulses that stand in for a fixed deglitch time. Only then does the block drop its oscillator-run output and force the gated clock low. When the request is withdrawn, the oscillator-run output rises again and the start-up lockout starts over.

Top module: `osc_out_gate`

## Requirements
- R1: The effective enable is `out_en_pin` OR `out_en_sw`; either one alone opens the gate, and with both low the gate closes.
- R2: Let `pwrdn_pin` be sampled high from rising edge a onward. The power-down filter counts `ref_tick` pulses sampled on edges a+2+PD_MIN_CYC and later. `osc_run` goes low just after the edge that counts the PD_TICKS-th pulse. A low sample of the pin at any earlier point restarts the whole count.
- R3: Once `osc_run` has been low for three rising edges, `clk_gated` stays low, whatever the enables do.
- R4: If `pwrdn_pin` is first sampled low at edge a while power-down is in force, `osc_run` is high after edge a+2 and the start-up lockout counts again from zero.
- R5: After reset release, with an enable held high, `clk_gated` stays low until its first high phase, which starts at rising edge STARTUP_CYC+3. Edges are counted from 1, starting with the first edge that samples `rst` low.
- R6: If the enable is first sampled high at edge k (lockout finished, no power-down), the first output high phase starts at edge k+2. If the enable is first sampled low at edge k, the high phase that starts at edge k+1 is the last one.
- R7: `clk_gated` is never high while `clk_osc` is low. When the gate is open, each output high phase covers the whole clock high phase.
- R8: While reset is held, `clk_gated` is low and `osc_run` is high.
- R9: A power-down pulse too short to pass the filter leaves `osc_run` high and the gated clock running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en_pin | input | 1 | Hardware output enable |
| out_en_sw | input | 1 | Software output enable bit |
| pwrdn_pin | input | 1 | Asynchronous power-down request |
| ref_tick | input | 1 | One-cycle reference pulse that times the deglitch window |
| clk_gated | output | 1 | Gated output clock |
| osc_run | output | 1 | High while the oscillator should run |

## Verification
A filter counter that is off by one moves the falling edge of `osc_run` by a whole tick spacing. A lockout counter that is off by one moves the first output pulse by one cycle. Both errors appear at the ports within a few dozen cycles, or within about 515 cycles after reset, and the per-cycle model catches them on the exact edge. A wrong stage count in the enable pipe shifts the first and last output phases by a cycle as soon as an enable toggles. A gate register clocked on the wrong edge shows up at the very next half-cycle sample as a runt or a missing pulse.

// File: rtl/oog_pkg.sv
package oog_pkg;

    typedef enum logic [1:0] {
        PD_IDLE      = 2'd0,
        PD_HOLD_CYC  = 2'd1,
        PD_HOLD_TIME = 2'd2,
        PD_DOWN      = 2'd3
    } pd_state_e;

    typedef struct packed {
        logic meta;
        logic stable;
    } sync2_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/oog_pdn_filter.sv
module oog_pdn_filter
    import oog_pkg::*;
#(
    parameter int PD_MIN_CYC = 2,
    parameter int PD_TICKS   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn_async,
    input  logic tick,
    output logic pd_down
);
    localparam int CW = cnt_bits(imax(PD_MIN_CYC, PD_TICKS));
    localparam logic [CW-1:0] CYC_LAST  = CW'(PD_MIN_CYC - 1);
    localparam logic [CW-1:0] TICK_LAST = CW'(PD_TICKS - 1);

    sync2_t    sync_q;
    pd_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q.meta   <= pdn_async;
            sync_q.stable <= sync_q.meta;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!sync_q.stable) begin
            st_d  = PD_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PD_IDLE: begin
                    st_d  = PD_HOLD_CYC;
                    cnt_d = CW'(1);
                end
                PD_HOLD_CYC: begin
                    if (cnt_q == CYC_LAST) begin
                        st_d  = PD_HOLD_TIME;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                PD_HOLD_TIME: begin
                    if (tick) begin
                        if (cnt_q == TICK_LAST) begin
                            st_d  = PD_DOWN;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                PD_DOWN: begin
                    st_d = PD_DOWN;
                end
                default: begin
                    st_d  = PD_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PD_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign pd_down = (st_q == PD_DOWN);

endmodule

// File: rtl/oog_startup_lock.sv
module oog_startup_lock
    import oog_pkg::*;
#(
    parameter int STARTUP_CYC = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic ready
);
    localparam int LW = cnt_bits(STARTUP_CYC);
    localparam logic [LW-1:0] LAST = LW'(STARTUP_CYC - 1);

    logic [LW-1:0] cnt_q;
    logic          ready_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            cnt_q <= cnt_q + LW'(1);
            if (cnt_q == LAST) begin
                ready_q <= 1'b1;
            end
        end
    end

    assign ready = ready_q;

endmodule

// File: rtl/oog_enable_pipe.sv
module oog_enable_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    output logic gate_q
);
    logic [LAT-1:0] stage_q;

    genvar gi;
    generate
        for (gi = 0; gi < LAT; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= en_req;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[gi] <= 1'b0;
                    else     stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= stage_q[LAT-1];
    end

endmodule

// File: rtl/osc_out_gate.sv
module osc_out_gate
    import oog_pkg::*;
#(
    parameter int STARTUP_CYC = 512,
    parameter int PD_MIN_CYC  = 2,
    parameter int PD_TICKS    = 10,
    parameter int EN_LAT      = 2
) (
    input  logic clk_osc,
    input  logic rst,
    input  logic out_en_pin,
    input  logic out_en_sw,
    input  logic pwrdn_pin,
    input  logic ref_tick,
    output logic clk_gated,
    output logic osc_run
);
    logic pd_down;
    logic ready;
    logic en_any;
    logic en_req;
    logic gate_q;

    oog_pdn_filter #(
        .PD_MIN_CYC (PD_MIN_CYC),
        .PD_TICKS   (PD_TICKS)
    ) u_filt (
        .clk       (clk_osc),
        .rst       (rst),
        .pdn_async (pwrdn_pin),
        .tick      (ref_tick),
        .pd_down   (pd_down)
    );

    oog_startup_lock #(
        .STARTUP_CYC (STARTUP_CYC)
    ) u_lock (
        .clk   (clk_osc),
        .rst   (rst),
        .hold  (pd_down),
        .ready (ready)
    );

    assign en_any = out_en_pin | out_en_sw;
    assign en_req = en_any & ready & ~pd_down;

    oog_enable_pipe #(
        .LAT (EN_LAT)
    ) u_pipe (
        .clk    (clk_osc),
        .rst    (rst),
        .en_req (en_req),
        .gate_q (gate_q)
    );

    assign clk_gated = clk_osc & gate_q;
    assign osc_run   = ~pd_down;

endmodule

// File: rtl/oog_checker.sv
module oog_checker (
    input logic clk,
    input logic rst,
    input logic en_pin,
    input logic en_sw,
    input logic pdn_pin,
    input logic osc_run,
    input logic ready,
    input logic gate_q
);
    // R1: two edges with no enable sampled close the gate
    p_gate_closed_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(en_pin | en_sw) == 1'b0 && $past(en_pin | en_sw, 2) == 1'b0) |-> !gate_q);

    // R2: power-down only after the pin was held high
    p_pd_needs_pin_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_run) |-> ($past(pdn_pin, 2) && $past(pdn_pin, 3)));

    // R3: gate shut while power-down persists
    p_down_gate_off_r3: assert property (@(posedge clk) disable iff (rst)
        (!osc_run && $past(osc_run) == 1'b0 && $past(osc_run, 2) == 1'b0) |-> !gate_q);

    // R5: lockout ends with the oscillator running and the gate still shut
    p_lock_end_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(osc_run) && !gate_q));

endmodule

bind osc_out_gate oog_checker u_chk (
    .clk     (clk_osc),
    .rst     (rst),
    .en_pin  (out_en_pin),
    .en_sw   (out_en_sw),
    .pdn_pin (pwrdn_pin),
    .osc_run (osc_run),
    .ready   (ready),
    .gate_q  (gate_q)
);

// File: tb/sim_osc_out_gate.sv
`timescale 1ns/1ps
module sim_osc_out_gate;
    localparam int STARTUP = 512;
    localparam int MINC    = 2;
    localparam int TICKS   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_pin = 1'b0, en_sw = 1'b0, pdn = 1'b0, tick = 1'b0;
    logic clk_gated, osc_run;

    int checks = 0, errors = 0;
    bit chk_on = 0, done = 0;
    string tag = "R8";

    always #2.5 clk = ~clk;

    osc_out_gate u0 (
        .clk_osc(clk), .rst(rst), .out_en_pin(en_pin), .out_en_sw(en_sw),
        .pwrdn_pin(pdn), .ref_tick(tick), .clk_gated(clk_gated), .osc_run(osc_run)
    );

    // behavioural reference model
    int m_run = 0, m_tk = 0, m_lk = 0;
    bit m_s1 = 0, m_s2 = 0, m_down = 0, m_ready = 0, m_e1 = 0, m_e2 = 0, m_g = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_run <= 0; m_tk <= 0; m_down <= 0;
            m_lk <= 0; m_ready <= 0; m_e1 <= 0; m_e2 <= 0;
        end else begin
            m_s1 <= pdn;
            m_s2 <= m_s1;
            if (!m_s2) begin
                m_run <= 0; m_tk <= 0; m_down <= 0;
            end else if (m_run < MINC) begin
                m_run <= m_run + 1;
            end else if (tick && m_tk < TICKS) begin
                m_tk <= m_tk + 1;
                if (m_tk + 1 == TICKS) m_down <= 1;
            end
            if (m_down) begin
                m_lk <= 0; m_ready <= 0;
            end else if (!m_ready) begin
                m_lk <= m_lk + 1;
                if (m_lk + 1 == STARTUP) m_ready <= 1;
            end
            m_e1 <= (en_pin | en_sw) && m_ready && !m_down;
            m_e2 <= m_e1;
        end
    end

    always @(negedge clk) begin
        if (rst) m_g <= 0;
        else     m_g <= m_e2;
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-clock comparison, both phases
    always @(posedge clk) begin
        #1.25;
        if (chk_on) begin
            chk(tag, clk_gated, m_g, "clk_gated high phase");
            chk(tag, osc_run, !m_down, "osc_run");
        end
    end
    always @(negedge clk) begin
        #1.25;
        if (chk_on) chk("R7", clk_gated, 1'b0, "clk_gated low phase");
    end

    // reference tick every third cycle
    int tcnt = 0;
    always @(posedge clk) begin
        #1;
        tcnt <= tcnt + 1;
        tick <= (tcnt % 3 == 0);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1.5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int first;
        step(3);
        chk_on = 1;
        // R8 reset state
        chk("R8", clk_gated, 1'b0, "reset clk_gated");
        chk("R8", osc_run, 1'b1, "reset osc_run");
        step(1);
        chk("R8", osc_run, 1'b1, "reset osc_run held");

        // R5 start-up lockout with enable held
        tag = "R5";
        en_pin = 1;
        rst = 0;
        first = 0;
        for (int n = 1; n <= 530; n++) begin
            @(posedge clk); #1.5;
            if (clk_gated && first == 0) first = n;
        end
        checks++;
        if (first != STARTUP + 3) begin
            errors++;
            $display("FAIL R5 first pulse edge: actual %0d expected %0d", first, STARTUP + 3);
        end

        // R1 either enable
        tag = "R1";
        en_pin = 0; en_sw = 1; step(6);
        chk("R1", clk_gated, 1'b1, "software enable alone");
        en_sw = 0; step(6);
        chk("R1", clk_gated, 1'b0, "both enables low");
        en_pin = 1; step(6);
        chk("R1", clk_gated, 1'b1, "pin enable alone");

        // R6 fixed latency on and off
        tag = "R6";
        en_pin = 0; step(6);
        en_pin = 1;
        step(1); chk("R6", clk_gated, 1'b0, "edge k");
        step(1); chk("R6", clk_gated, 1'b0, "edge k+1");
        step(1); chk("R6", clk_gated, 1'b1, "edge k+2 first pulse");
        step(3);
        en_pin = 0;
        step(1); chk("R6", clk_gated, 1'b1, "off edge k");
        step(1); chk("R6", clk_gated, 1'b1, "off edge k+1 last pulse");
        step(1); chk("R6", clk_gated, 1'b0, "off edge k+2");
        en_pin = 1; step(6);

        // R9 short power-down pulse ignored
        tag = "R9";
        pdn = 1; step(8); pdn = 0; step(10);
        chk("R9", osc_run, 1'b1, "short pulse osc_run");
        chk("R9", clk_gated, 1'b1, "short pulse output running");

        // R2 and R3 sustained power-down
        tag = "R2";
        pdn = 1; step(45);
        chk("R2", osc_run, 1'b0, "power-down accepted");
        tag = "R3";
        en_sw = 1; step(20);
        chk("R3", clk_gated, 1'b0, "output held off");

        // R4 release and lockout restart
        tag = "R4";
        pdn = 0; step(3);
        chk("R4", osc_run, 1'b1, "released");
        step(300);
        chk("R4", clk_gated, 1'b0, "lockout restarted");
        step(230);
        chk("R4", clk_gated, 1'b1, "output back after lockout");
        step(5);
        finish_run();
    end
endmodule